// File: doc/BRIEF.md
# Indirect Interrupt Source Configuration Bank

This block keeps the per-source configuration for a parameterised number of interrupt inputs, up to 128, and reaches all of it through a small indirect window. Software first writes a source number into a select register. Every later access to the mode register, the vector register or one of the four command registers then acts on that one source only. The mode register holds a three-bit priority and a two-bit trigger type. The vector register holds a value that a downstream arbiter hands out when the source wins. The four command registers enable the source, disable it, drop its pending bit, or force its pending bit.

Each raw input passes through a two-flop synchronizer. It is then turned into a pending bit according to the programmed trigger type. A level source follows its input. An edge source is captured and held until software clears it or the arbiter acknowledges it. The bank drives flat vectors of pending and enable bits, plus every source's priority and vector, to an arbiter that lives outside this block. Writes take effect on the clock edge that samples them. Reads are combinational from the current address and the registered select value.

Top module: `irq_cfg_bank`

## Requirements
- R1: After reset, all enable and pending bits are 0, every priority is 0, every trigger type is active-high level, every vector is 0, and the select register reads 0.
- R2: A write to offset 0x00 stores bits [6:0] of the write data as the selected source. Higher write bits are dropped, and a read of offset 0x00 returns the 7-bit index with zeros above it.
- R3: Offset 0x04 reads and writes the selected source's mode: priority in bits [2:0], trigger type in bits [6:5], all other bits reading 0. A write changes only the selected source, so a read-modify-write of one field leaves that source's other field and all other sources intact.
- R4: Offset 0x08 reads and writes the selected source's VEC_W-bit vector, which appears on that source's slice of src_vector.
- R5: A write to 0x40 (enable) or 0x44 (disable) with write bit 0 set sets or clears only the selected source's enable bit. Such a write with bit 0 clear has no effect.
- R6: Trigger type 2 (active-high level) and 0 (active-low level) make the pending bit follow the synchronized input level. The input reaches the pending output two clocks after it is sampled.
- R7: Trigger type 3 (rising edge) and 1 (falling edge) capture a pending bit on the matching transition only. The bit stays set after the input returns, until it is cleared or acknowledged.
- R8: A write of 1 to 0x4C (set) forces the selected source pending. For a level source it stays pending while the input is inactive, until a clear.
- R9: A write of 1 to 0x48 (clear) drops the selected source's captured or forced pending. A level source whose input is still active stays pending.
- R10: While the select value is at or above NUM_SRC, mode and vector read 0, and mode writes, vector writes and all commands have no effect.
- R11: The command offsets 0x40 to 0x4C, and every unmapped offset, read 0.
- R12: A cycle with ack_valid high clears the captured pending bit of edge source ack_idx only. It leaves a level source's input-driven pending in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Raw interrupt inputs, asynchronous to clk |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ack_valid | input | 1 | Acknowledge from the arbiter |
| ack_idx | input | 7 | Source being acknowledged |
| src_pending | output | NUM_SRC | Pending bit per source |
| src_enable | output | NUM_SRC | Enable bit per source |
| src_prio | output | 3*NUM_SRC | Priority per source, source i at [3i+2:3i] |
| src_vector | output | VEC_W*NUM_SRC | Vector per source, source i at [VEC_W*i +: VEC_W] |

## Verification
The hardest case to reach is a falling-edge source. It must show no pending bit on a rising input, capture one on the later fall, and then lose it only through the acknowledge port while a neighbouring level source holds its own pending bit through an acknowledge. The stimulus programs the trigger type while the input is low, then walks the input high and low with waits longer than the synchronizer delay, then pulses the acknowledge. Select values beyond the implemented sources are also exercised: mode writes, enable and set commands are issued there, and the enable and pending vectors are compared against a snapshot taken before those writes.

// File: rtl/irq_cfg_pkg.sv
package irq_cfg_pkg;

  localparam logic [7:0] OFF_SEL  = 8'h00;
  localparam logic [7:0] OFF_MODE = 8'h04;
  localparam logic [7:0] OFF_VEC  = 8'h08;
  localparam logic [7:0] OFF_EN   = 8'h40;
  localparam logic [7:0] OFF_DIS  = 8'h44;
  localparam logic [7:0] OFF_CLR  = 8'h48;
  localparam logic [7:0] OFF_SET  = 8'h4C;

  localparam int IDX_W  = 7;
  localparam int PRIO_W = 3;

  // trigger type: bit 1 = polarity (1 high/rising), bit 0 = edge mode
  typedef enum logic [1:0] {
    TRIG_LVL_LO    = 2'd0,
    TRIG_EDGE_FALL = 2'd1,
    TRIG_LVL_HI    = 2'd2,
    TRIG_EDGE_RISE = 2'd3
  } trig_e;

endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/irq_cfg_cell.sv
module irq_cfg_cell
  import irq_cfg_pkg::*;
#(
  parameter int VEC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_raw,
  input  logic              wr_mode,
  input  logic [PRIO_W-1:0] prio_w,
  input  logic [1:0]        trig_w,
  input  logic              wr_vec,
  input  logic [VEC_W-1:0]  vec_w,
  input  logic              cmd_en,
  input  logic              cmd_dis,
  input  logic              cmd_clr,
  input  logic              cmd_set,
  input  logic              ack,
  output logic              en_o,
  output logic              pend_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [1:0]        trig_o,
  output logic [VEC_W-1:0]  vec_o
);

  logic              smp;
  logic              prev_q, prev_d;
  logic              lat_q, lat_d;
  logic              en_q, en_d;
  logic [PRIO_W-1:0] prio_q, prio_d;
  logic [1:0]        trig_q, trig_d;
  logic [VEC_W-1:0]  vec_q, vec_d;
  logic              edge_mode;
  logic              edge_hit;
  logic              level_hit;

  irq_sync2 u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (irq_raw),
    .q_o   (smp)
  );

  assign edge_mode = trig_q[0];

  always_comb begin
    edge_hit  = 1'b0;
    level_hit = 1'b0;
    if (edge_mode) begin
      edge_hit = trig_q[1] ? (smp & ~prev_q) : (~smp & prev_q);
    end else begin
      level_hit = trig_q[1] ? smp : ~smp;
    end
  end

  always_comb begin
    prev_d = smp;
    lat_d  = lat_q;
    en_d   = en_q;
    prio_d = prio_q;
    trig_d = trig_q;
    vec_d  = vec_q;
    if (edge_hit || cmd_set) begin
      lat_d = 1'b1;
    end else if (cmd_clr || (ack && edge_mode)) begin
      lat_d = 1'b0;
    end
    if (cmd_en) begin
      en_d = 1'b1;
    end else if (cmd_dis) begin
      en_d = 1'b0;
    end
    if (wr_mode) begin
      prio_d = prio_w;
      trig_d = trig_w;
    end
    if (wr_vec) begin
      vec_d = vec_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
      en_q   <= 1'b0;
      prio_q <= '0;
      trig_q <= TRIG_LVL_HI;
      vec_q  <= '0;
    end else begin
      prev_q <= prev_d;
      lat_q  <= lat_d;
      en_q   <= en_d;
      prio_q <= prio_d;
      trig_q <= trig_d;
      vec_q  <= vec_d;
    end
  end

  assign en_o   = en_q;
  assign pend_o = lat_q | level_hit;
  assign prio_o = prio_q;
  assign trig_o = trig_q;
  assign vec_o  = vec_q;

  assert_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_en |=> en_o);
  assert_disable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_dis && !cmd_en) |=> !en_o);
  assert_set_pends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_set |=> pend_o);
  assert_edge_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && lat_q && !cmd_clr && !ack) |=> lat_q);
  assert_clear_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr && !edge_hit && !cmd_set) |=> !lat_q);
  assert_mode_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mode |=> $stable({prio_o, trig_o}));

endmodule

// File: rtl/irq_cfg_regif.sv
module irq_cfg_regif
  import irq_cfg_pkg::*;
#(
  parameter int NUM_SRC = 50,
  parameter int VEC_W   = 32,
  parameter int DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic [7:0]                bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic [PRIO_W*NUM_SRC-1:0] prio_flat,
  input  logic [2*NUM_SRC-1:0]      trig_flat,
  input  logic [VEC_W*NUM_SRC-1:0]  vec_flat,
  output logic [NUM_SRC-1:0]        wr_mode_o,
  output logic [NUM_SRC-1:0]        wr_vec_o,
  output logic [NUM_SRC-1:0]        cmd_en_o,
  output logic [NUM_SRC-1:0]        cmd_dis_o,
  output logic [NUM_SRC-1:0]        cmd_clr_o,
  output logic [NUM_SRC-1:0]        cmd_set_o
);

  localparam logic [7:0] NSRC8 = 8'(NUM_SRC);

  logic [IDX_W-1:0] sel_q, sel_d;
  logic             sel_ok;
  logic             hit_mode, hit_vec, hit_en, hit_dis, hit_clr, hit_set;
  logic [6:0]       mode_rd;
  logic [VEC_W-1:0] vec_rd;

  assign sel_ok = ({1'b0, sel_q} < NSRC8);

  always_comb begin
    sel_d = sel_q;
    if (bus_wr && bus_addr == OFF_SEL) begin
      sel_d = bus_wdata[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else begin
      sel_q <= sel_d;
    end
  end

  assign hit_mode = bus_wr && bus_addr == OFF_MODE;
  assign hit_vec  = bus_wr && bus_addr == OFF_VEC;
  assign hit_en   = bus_wr && bus_addr == OFF_EN  && bus_wdata[0];
  assign hit_dis  = bus_wr && bus_addr == OFF_DIS && bus_wdata[0];
  assign hit_clr  = bus_wr && bus_addr == OFF_CLR && bus_wdata[0];
  assign hit_set  = bus_wr && bus_addr == OFF_SET && bus_wdata[0];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_strobe
    logic match;
    assign match        = (sel_q == IDX_W'(i));
    assign wr_mode_o[i] = hit_mode & match;
    assign wr_vec_o[i]  = hit_vec  & match;
    assign cmd_en_o[i]  = hit_en   & match;
    assign cmd_dis_o[i] = hit_dis  & match;
    assign cmd_clr_o[i] = hit_clr  & match;
    assign cmd_set_o[i] = hit_set  & match;
  end

  always_comb begin
    mode_rd = '0;
    vec_rd  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel_q == IDX_W'(i)) begin
        mode_rd = {trig_flat[2*i +: 2], 2'b00, prio_flat[PRIO_W*i +: PRIO_W]};
        vec_rd  = vec_flat[VEC_W*i +: VEC_W];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_SEL:  bus_rdata = DATA_W'(sel_q);
      OFF_MODE: bus_rdata = DATA_W'(mode_rd);
      OFF_VEC:  bus_rdata = DATA_W'(vec_rd);
      default:  bus_rdata = '0;
    endcase
  end

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_mode_o, wr_vec_o, cmd_en_o, cmd_dis_o, cmd_clr_o, cmd_set_o}));
  assert_oob_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ok |-> ({wr_mode_o, wr_vec_o, cmd_en_o, cmd_dis_o, cmd_clr_o, cmd_set_o} == '0));
  assert_sel_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_SEL) |=> (sel_q == $past(bus_wdata[IDX_W-1:0])));

endmodule

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank
  import irq_cfg_pkg::*;
#(
  parameter int NUM_SRC = 50,
  parameter int VEC_W   = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        irq_in,
  input  logic                      bus_wr,
  input  logic [7:0]                bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic                      ack_valid,
  input  logic [6:0]                ack_idx,
  output logic [NUM_SRC-1:0]        src_pending,
  output logic [NUM_SRC-1:0]        src_enable,
  output logic [PRIO_W*NUM_SRC-1:0] src_prio,
  output logic [VEC_W*NUM_SRC-1:0]  src_vector
);

  localparam int DATA_W = 32;

  logic [2*NUM_SRC-1:0] trig_flat;
  logic [NUM_SRC-1:0]   wr_mode, wr_vec, cmd_en, cmd_dis, cmd_clr, cmd_set;

  irq_cfg_regif #(
    .NUM_SRC (NUM_SRC),
    .VEC_W   (VEC_W),
    .DATA_W  (DATA_W)
  ) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .prio_flat (src_prio),
    .trig_flat (trig_flat),
    .vec_flat  (src_vector),
    .wr_mode_o (wr_mode),
    .wr_vec_o  (wr_vec),
    .cmd_en_o  (cmd_en),
    .cmd_dis_o (cmd_dis),
    .cmd_clr_o (cmd_clr),
    .cmd_set_o (cmd_set)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic ack_hit;
    assign ack_hit = ack_valid && (ack_idx == IDX_W'(i));

    irq_cfg_cell #(.VEC_W(VEC_W)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_raw (irq_in[i]),
      .wr_mode (wr_mode[i]),
      .prio_w  (bus_wdata[PRIO_W-1:0]),
      .trig_w  (bus_wdata[6:5]),
      .wr_vec  (wr_vec[i]),
      .vec_w   (bus_wdata[VEC_W-1:0]),
      .cmd_en  (cmd_en[i]),
      .cmd_dis (cmd_dis[i]),
      .cmd_clr (cmd_clr[i]),
      .cmd_set (cmd_set[i]),
      .ack     (ack_hit),
      .en_o    (src_enable[i]),
      .pend_o  (src_pending[i]),
      .prio_o  (src_prio[PRIO_W*i +: PRIO_W]),
      .trig_o  (trig_flat[2*i +: 2]),
      .vec_o   (src_vector[VEC_W*i +: VEC_W])
    );
  end

endmodule

// File: tb/irq_cfg_bank_tb.sv
module irq_cfg_bank_tb;

  localparam int NUM_SRC = 50;
  localparam int VEC_W   = 32;

  logic                     clk;
  logic                     rst_n;
  logic [NUM_SRC-1:0]       irq_in;
  logic                     bus_wr;
  logic [7:0]               bus_addr;
  logic [31:0]              bus_wdata;
  logic [31:0]              bus_rdata;
  logic                     ack_valid;
  logic [6:0]               ack_idx;
  logic [NUM_SRC-1:0]       src_pending;
  logic [NUM_SRC-1:0]       src_enable;
  logic [3*NUM_SRC-1:0]     src_prio;
  logic [VEC_W*NUM_SRC-1:0] src_vector;

  int n_chk  = 0;
  int n_fail = 0;

  irq_cfg_bank #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_in      (irq_in),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .ack_valid   (ack_valid),
    .ack_idx     (ack_idx),
    .src_pending (src_pending),
    .src_enable  (src_enable),
    .src_prio    (src_prio),
    .src_vector  (src_vector)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] r;
    brd(8'h00, r); chk("R1 select", 64'(r), 64'h0);
    brd(8'h04, r); chk("R1 mode", 64'(r), 64'h40);
    brd(8'h08, r); chk("R1 vector", 64'(r), 64'h0);
    chk("R1 pending", 64'(src_pending), 64'h0);
    chk("R1 enable", 64'(src_enable), 64'h0);
    chk("R1 prio", 64'(src_prio[2:0]), 64'h0);
  endtask

  task automatic t_select;
    logic [31:0] r;
    bwr(8'h00, 32'hFFFF_FF85);
    brd(8'h00, r); chk("R2 select upper bits dropped", 64'(r), 64'h05);
  endtask

  task automatic t_mode;
    logic [31:0] r;
    bwr(8'h00, 32'd5);
    bwr(8'h04, 32'hFFFF_FFFF);
    brd(8'h04, r); chk("R3 mode fields", 64'(r), 64'h67);
    chk("R3 prio out", 64'(src_prio[15 +: 3]), 64'h7);
    bwr(8'h00, 32'd6);
    brd(8'h04, r); chk("R3 neighbour untouched", 64'(r), 64'h40);
    bwr(8'h00, 32'd5);
    brd(8'h04, r);
    bwr(8'h04, (r & ~32'h7) | 32'h2);
    brd(8'h04, r); chk("R3 read-modify-write", 64'(r), 64'h62);
  endtask

  task automatic t_vector;
    logic [31:0] r;
    bwr(8'h00, 32'd9);
    bwr(8'h08, 32'hDEAD_BEEF);
    brd(8'h08, r); chk("R4 vector readback", 64'(r), 64'hDEAD_BEEF);
    chk("R4 vector out", 64'(src_vector[9*VEC_W +: VEC_W]), 64'hDEAD_BEEF);
    chk("R4 other vector", 64'(src_vector[8*VEC_W +: VEC_W]), 64'h0);
  endtask

  task automatic t_enable;
    bwr(8'h00, 32'd3);
    bwr(8'h40, 32'h0000_0002);
    chk("R5 enable bit0 clear ignored", 64'(src_enable), 64'h0);
    bwr(8'h40, 32'h1);
    chk("R5 enable only selected", 64'(src_enable), 64'h8);
    bwr(8'h44, 32'h1);
    chk("R5 disable", 64'(src_enable), 64'h0);
  endtask

  task automatic t_level;
    irq_in[10] = 1'b1; cyc(4);
    chk("R6 high level pending", 64'(src_pending[10]), 64'h1);
    irq_in[10] = 1'b0; cyc(4);
    chk("R6 high level follows", 64'(src_pending[10]), 64'h0);
    bwr(8'h00, 32'd11);
    bwr(8'h04, 32'h00);
    cyc(2);
    chk("R6 low level pending", 64'(src_pending[11]), 64'h1);
    irq_in[11] = 1'b1; cyc(4);
    chk("R6 low level released", 64'(src_pending[11]), 64'h0);
  endtask

  task automatic t_edge;
    bwr(8'h00, 32'd12);
    bwr(8'h04, 32'h60);
    irq_in[12] = 1'b1; cyc(3);
    irq_in[12] = 1'b0; cyc(6);
    chk("R7 rising captured and held", 64'(src_pending[12]), 64'h1);
    bwr(8'h48, 32'h1); cyc(1);
    chk("R7 clear rising", 64'(src_pending[12]), 64'h0);
    bwr(8'h00, 32'd13);
    bwr(8'h04, 32'h20);
    cyc(3);
    irq_in[13] = 1'b1; cyc(6);
    chk("R7 falling ignores rise", 64'(src_pending[13]), 64'h0);
    irq_in[13] = 1'b0; cyc(6);
    chk("R7 falling captured", 64'(src_pending[13]), 64'h1);
  endtask

  task automatic t_ack;
    irq_in[16] = 1'b1; cyc(4);
    @(negedge clk); ack_valid = 1'b1; ack_idx = 7'd16;
    @(negedge clk); ack_valid = 1'b0;
    cyc(1);
    chk("R12 level unaffected by ack", 64'(src_pending[16]), 64'h1);
    chk("R12 other edge source kept", 64'(src_pending[13]), 64'h1);
    @(negedge clk); ack_valid = 1'b1; ack_idx = 7'd13;
    @(negedge clk); ack_valid = 1'b0;
    cyc(1);
    chk("R12 ack clears edge", 64'(src_pending[13]), 64'h0);
    irq_in[16] = 1'b0;
  endtask

  task automatic t_setclr;
    bwr(8'h00, 32'd14);
    bwr(8'h4C, 32'h1); cyc(4);
    chk("R8 set holds on level source", 64'(src_pending[14]), 64'h1);
    bwr(8'h48, 32'h1); cyc(1);
    chk("R9 clear forced", 64'(src_pending[14]), 64'h0);
    irq_in[15] = 1'b1; cyc(4);
    bwr(8'h00, 32'd15);
    bwr(8'h4C, 32'h1);
    bwr(8'h48, 32'h1); cyc(1);
    chk("R9 active level stays", 64'(src_pending[15]), 64'h1);
    irq_in[15] = 1'b0; cyc(4);
    chk("R9 level drops after input", 64'(src_pending[15]), 64'h0);
  endtask

  task automatic t_oob;
    logic [31:0] r;
    logic [NUM_SRC-1:0] snap;
    cyc(4);
    snap = src_pending;
    bwr(8'h00, 32'd60);
    brd(8'h00, r); chk("R10 select reads 60", 64'(r), 64'd60);
    bwr(8'h04, 32'h67);
    brd(8'h04, r); chk("R10 mode reads 0", 64'(r), 64'h0);
    bwr(8'h08, 32'h1234);
    brd(8'h08, r); chk("R10 vector reads 0", 64'(r), 64'h0);
    bwr(8'h40, 32'h1);
    bwr(8'h4C, 32'h1); cyc(2);
    chk("R10 enable ignored", 64'(src_enable), 64'h0);
    chk("R10 set ignored", 64'(src_pending), 64'(snap));
    bwr(8'h00, 32'd0);
    brd(8'h04, r); chk("R10 source 0 mode intact", 64'(r), 64'h40);
  endtask

  task automatic t_cmdread;
    logic [31:0] r;
    bwr(8'h00, 32'd9);
    brd(8'h40, r); chk("R11 enable reads 0", 64'(r), 64'h0);
    brd(8'h48, r); chk("R11 clear reads 0", 64'(r), 64'h0);
    brd(8'h4C, r); chk("R11 set reads 0", 64'(r), 64'h0);
    brd(8'h10, r); chk("R11 unmapped reads 0", 64'(r), 64'h0);
  endtask

  initial begin
    rst_n = 1'b0; irq_in = '0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; ack_valid = 1'b0; ack_idx = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset;
    t_select;
    t_mode;
    t_vector;
    t_enable;
    t_level;
    t_edge;
    t_ack;
    t_setclr;
    t_oob;
    t_cmdread;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule